// File: doc/BRIEF.md
# CPU Debug Run-Control Unit

This block sits between a byte-wide host command link (the receive and transmit sides of a serial port) and a soft CPU core under test. After reset the core is frozen. The host then steers it with one-byte commands. It can stream a program into instruction memory, let the core run freely, advance it by one retired instruction or by one clock cycle, stop it, and read back register or memory contents.

The unit drives a clock-enable and a stall line into the core. It watches the core's one-cycle retire strobe to end an instruction step. It writes program words into instruction memory through a dedicated write port. While the core is stopped, it can also take the shared memory read bus for itself. Register contents come from a combinational snoop port on the core's register file. All replies go back byte by byte over a valid/ready transmit interface.

Top module: `dbg_runctl`

## Requirements
- R1: After reset the core is stopped: `core_clk_en` is 0, `core_stall` is 1, `tx_valid` is 0, `bus_own` is 0 and `imem_we` is 0.
- R2: Command 0x10 (free-run), received while stopped and outside a load phase, raises `core_clk_en` from the second cycle after the command byte. It stays high until a stop command arrives.
- R3: Command 0x12 (cycle step) holds `core_clk_en` high for exactly one clock cycle, then low again.
- R4: Command 0x11 (instruction step) keeps `core_clk_en` high until and including the cycle in which `core_retire` is high. From the next cycle it is low, so exactly one instruction retires.
- R5: Command 0x13 (stop) drops `core_clk_en` from the second cycle after the stop byte. It always answers with the single byte 0xA5, whether or not the core was running.
- R6: Command 0x01 (load begin), received while stopped, is followed by a 2-byte little-endian byte count N and then N raw bytes of any value. The bytes are packed little-endian into 32-bit words written at word addresses 0, 1, 2, and so on. A word is written only when its fourth byte arrives, and a trailing partial word is dropped.
- R7: Between load begin and command 0x02 (load end), the run and step commands are ignored. After 0x02 they are accepted again.
- R8: Command 0x20, followed by an index byte whose low 5 bits select the register, returns the 4-byte snoop value least-significant byte first. Each reply byte is held stable on `tx_data` while `tx_valid` is high and `tx_ready` is low.
- R9: Command 0x21, followed by a 4-byte little-endian byte address, raises `bus_own` for two cycles with `bus_rd` high in the first cycle only. The data is taken from `bus_rdata` one cycle after `bus_rd` and returned as 4 bytes least-significant byte first.
- R10: A read command (0x20 or 0x21) whose command byte arrives while the core is not stopped still consumes its argument bytes. It returns the single byte 0xEE and does not take the bus.
- R11: A stop command that arrives in the same cycle as the retire strobe of an instruction step leaves the core stopped after exactly that one instruction and produces exactly one 0xA5.
- R12: Whenever `bus_own` or `imem_we` is high, `core_stall` is high and `core_clk_en` is low.
- R13: A byte that is not a known command, or a load end outside a load phase, produces no reply and no change to the run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a host byte is present |
| rx_data | input | 8 | Host byte |
| tx_valid | output | 1 | Reply byte available |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter accepts the reply byte |
| core_clk_en | output | 1 | Clock enable to the core |
| core_stall | output | 1 | Stall request to the core |
| core_retire | input | 1 | One-cycle instruction retire strobe from the core |
| imem_we | output | 1 | Program word write strobe |
| imem_waddr | output | IMEM_AW | Program word address |
| imem_wdata | output | 32 | Program word |
| snoop_idx | output | REG_IDX_W | Register file snoop index |
| snoop_data | input | 32 | Register file snoop value |
| bus_own | output | 1 | Unit owns the memory read bus |
| bus_rd | output | 1 | Memory read strobe |
| bus_addr | output | 32 | Memory byte address |
| bus_rdata | input | 32 | Memory read data, valid one cycle after `bus_rd` |

## Verification
The collision that matters is between ending an instruction step and obeying a stop. Both act on the run state in the same edge, and both could claim the stop acknowledgement. The bench uses a model core that retires every third enabled cycle. It first steps to an instruction boundary, then sends the step byte and the stop byte exactly three cycles apart, so the stop pulse meets the retire strobe. It judges the outcome at the ports: exactly three enabled cycles, a retire counter read back through the snoop that rose by one, and a single 0xA5 on the transmit side.

// File: rtl/dbg_runctl_pkg.sv
package dbg_runctl_pkg;

   typedef enum logic [1:0] {
      RM_HALT  = 2'd0,
      RM_FREE  = 2'd1,
      RM_INSTR = 2'd2,
      RM_CYCLE = 2'd3
   } run_mode_e;

   typedef enum logic [2:0] {
      PS_CMD  = 3'd0,
      PS_IDX  = 3'd1,
      PS_ADDR = 3'd2,
      PS_LEN  = 3'd3,
      PS_DATA = 3'd4
   } parse_st_e;

   typedef enum logic [1:0] {
      RB_IDLE = 2'd0,
      RB_REQ  = 2'd1,
      RB_CAP  = 2'd2
   } rb_st_e;

   localparam logic [7:0] OP_LOAD_OPEN  = 8'h01;
   localparam logic [7:0] OP_LOAD_CLOSE = 8'h02;
   localparam logic [7:0] OP_FREE_RUN   = 8'h10;
   localparam logic [7:0] OP_STEP_INSTR = 8'h11;
   localparam logic [7:0] OP_STEP_CYCLE = 8'h12;
   localparam logic [7:0] OP_STOP       = 8'h13;
   localparam logic [7:0] OP_PEEK_REG   = 8'h20;
   localparam logic [7:0] OP_PEEK_MEM   = 8'h21;

   localparam logic [7:0] RSP_STOPPED   = 8'hA5;
   localparam logic [7:0] RSP_REFUSED   = 8'hEE;

   localparam int unsigned WORD_BYTES   = 4;

endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
   import dbg_runctl_pkg::*;
#(
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned REG_IDX_W = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_valid,
   input  logic [7:0]           rx_data,
   input  logic                 halted,
   input  logic                 loading,
   output logic                 go_run,
   output logic                 go_instr,
   output logic                 go_cycle,
   output logic                 go_stop,
   output logic                 load_open,
   output logic                 load_close,
   output logic                 load_byte_v,
   output logic [7:0]           load_byte,
   output logic                 peek_reg,
   output logic                 peek_mem,
   output logic                 peek_refused,
   output logic [REG_IDX_W-1:0] reg_idx,
   output logic [31:0]          mem_addr
);

   localparam int unsigned LEN_BYTES = LEN_W / 8;
   localparam int unsigned ARG_MAX   = (LEN_BYTES > WORD_BYTES) ? LEN_BYTES : WORD_BYTES;
   localparam int unsigned CNT_W     = $clog2(ARG_MAX) + 1;

   parse_st_e        st_q;
   logic [CNT_W-1:0] arg_q;
   logic [LEN_W-1:0] len_q;
   logic             refuse_q;
   logic [LEN_W-1:0] len_next;
   logic             addr_last;
   logic             len_last;

   assign len_next  = {rx_data, len_q[LEN_W-1:8]};
   assign addr_last = (arg_q == CNT_W'(WORD_BYTES - 1));
   assign len_last  = (arg_q == CNT_W'(LEN_BYTES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= PS_CMD;
         arg_q        <= '0;
         len_q        <= '0;
         refuse_q     <= 1'b0;
         go_run       <= 1'b0;
         go_instr     <= 1'b0;
         go_cycle     <= 1'b0;
         go_stop      <= 1'b0;
         load_open    <= 1'b0;
         load_close   <= 1'b0;
         load_byte_v  <= 1'b0;
         load_byte    <= '0;
         peek_reg     <= 1'b0;
         peek_mem     <= 1'b0;
         peek_refused <= 1'b0;
         reg_idx      <= '0;
         mem_addr     <= '0;
      end else begin
         go_run       <= 1'b0;
         go_instr     <= 1'b0;
         go_cycle     <= 1'b0;
         go_stop      <= 1'b0;
         load_open    <= 1'b0;
         load_close   <= 1'b0;
         load_byte_v  <= 1'b0;
         peek_reg     <= 1'b0;
         peek_mem     <= 1'b0;
         peek_refused <= 1'b0;
         if (rx_valid) begin
            case (st_q)
               PS_CMD: begin
                  case (rx_data)
                     OP_LOAD_OPEN: begin
                        if (halted && !loading) begin
                           load_open <= 1'b1;
                           arg_q     <= '0;
                           st_q      <= PS_LEN;
                        end
                     end
                     OP_LOAD_CLOSE: load_close <= loading;
                     OP_FREE_RUN:   go_run     <= 1'b1;
                     OP_STEP_INSTR: go_instr   <= 1'b1;
                     OP_STEP_CYCLE: go_cycle   <= 1'b1;
                     OP_STOP:       go_stop    <= 1'b1;
                     OP_PEEK_REG: begin
                        refuse_q <= !halted;
                        st_q     <= PS_IDX;
                     end
                     OP_PEEK_MEM: begin
                        refuse_q <= !halted;
                        arg_q    <= '0;
                        st_q     <= PS_ADDR;
                     end
                     default: ;
                  endcase
               end
               PS_IDX: begin
                  if (refuse_q) begin
                     peek_refused <= 1'b1;
                  end else begin
                     reg_idx  <= rx_data[REG_IDX_W-1:0];
                     peek_reg <= 1'b1;
                  end
                  st_q <= PS_CMD;
               end
               PS_ADDR: begin
                  mem_addr <= {rx_data, mem_addr[31:8]};
                  arg_q    <= arg_q + 1'b1;
                  if (addr_last) begin
                     st_q         <= PS_CMD;
                     peek_refused <= refuse_q;
                     peek_mem     <= !refuse_q;
                  end
               end
               PS_LEN: begin
                  len_q <= len_next;
                  arg_q <= arg_q + 1'b1;
                  if (len_last) begin
                     st_q <= (len_next == '0) ? PS_CMD : PS_DATA;
                  end
               end
               PS_DATA: begin
                  load_byte_v <= 1'b1;
                  load_byte   <= rx_data;
                  len_q       <= len_q - 1'b1;
                  if (len_q == LEN_W'(1)) begin
                     st_q <= PS_CMD;
                  end
               end
               default: st_q <= PS_CMD;
            endcase
         end
      end
   end

endmodule

// File: rtl/dbg_prog_loader.sv
module dbg_prog_loader
   import dbg_runctl_pkg::*;
#(
   parameter int unsigned AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_open,
   input  logic          load_close,
   input  logic          byte_v,
   input  logic [7:0]    byte_d,
   output logic          loading,
   output logic          imem_we,
   output logic [AW-1:0] imem_waddr,
   output logic [31:0]   imem_wdata
);

   localparam int unsigned LANE_W   = $clog2(WORD_BYTES);
   localparam int unsigned HELD     = WORD_BYTES - 1;
   localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(WORD_BYTES - 1);

   logic [LANE_W-1:0] lane_q;
   logic [AW-1:0]     next_waddr_q;
   logic [HELD*8-1:0] lower_bytes;

   for (genvar g = 0; g < HELD; g++) begin : g_lane
      logic [7:0] held_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            held_q <= '0;
         end else if (byte_v && lane_q == LANE_W'(g)) begin
            held_q <= byte_d;
         end
      end
      assign lower_bytes[g*8 +: 8] = held_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loading      <= 1'b0;
         lane_q       <= '0;
         next_waddr_q <= '0;
         imem_we      <= 1'b0;
         imem_waddr   <= '0;
         imem_wdata   <= '0;
      end else begin
         imem_we <= 1'b0;
         if (load_open) begin
            loading      <= 1'b1;
            lane_q       <= '0;
            next_waddr_q <= '0;
         end else if (load_close) begin
            loading <= 1'b0;
         end else if (byte_v && loading) begin
            lane_q <= lane_q + 1'b1;
            if (lane_q == TOP_LANE) begin
               imem_we      <= 1'b1;
               imem_waddr   <= next_waddr_q;
               imem_wdata   <= {byte_d, lower_bytes};
               next_waddr_q <= next_waddr_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/dbg_exec_ctl.sv
module dbg_exec_ctl
   import dbg_runctl_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      go_run,
   input  logic      go_instr,
   input  logic      go_cycle,
   input  logic      go_stop,
   input  logic      retire,
   input  logic      loading,
   input  logic      bus_busy,
   output run_mode_e mode,
   output logic      core_clk_en,
   output logic      core_stall
);

   run_mode_e mode_q;
   logic      can_start;

   assign can_start = (mode_q == RM_HALT) && !loading && !bus_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= RM_HALT;
      end else if (go_stop) begin
         mode_q <= RM_HALT;
      end else begin
         case (mode_q)
            RM_HALT: begin
               if (can_start) begin
                  if (go_run)        mode_q <= RM_FREE;
                  else if (go_instr) mode_q <= RM_INSTR;
                  else if (go_cycle) mode_q <= RM_CYCLE;
               end
            end
            RM_INSTR: if (retire) mode_q <= RM_HALT;
            RM_CYCLE: mode_q <= RM_HALT;
            default:  ;
         endcase
      end
   end

   assign mode        = mode_q;
   assign core_clk_en = (mode_q != RM_HALT);
   assign core_stall  = (mode_q == RM_HALT);

endmodule

// File: rtl/dbg_readback.sv
module dbg_readback
   import dbg_runctl_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        peek_reg,
   input  logic        peek_mem,
   input  logic [31:0] reg_data,
   input  logic [31:0] mem_rdata,
   output logic        bus_own,
   output logic        bus_rd,
   output logic        busy,
   output logic        word_v,
   output logic [31:0] word
);

   rb_st_e st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= RB_IDLE;
         word_v <= 1'b0;
         word   <= '0;
      end else begin
         word_v <= 1'b0;
         case (st_q)
            RB_IDLE: begin
               if (peek_reg) begin
                  word_v <= 1'b1;
                  word   <= reg_data;
               end else if (peek_mem) begin
                  st_q <= RB_REQ;
               end
            end
            RB_REQ: st_q <= RB_CAP;
            RB_CAP: begin
               word_v <= 1'b1;
               word   <= mem_rdata;
               st_q   <= RB_IDLE;
            end
            default: st_q <= RB_IDLE;
         endcase
      end
   end

   assign bus_own = (st_q != RB_IDLE);
   assign bus_rd  = (st_q == RB_REQ);
   assign busy    = bus_own;

endmodule

// File: rtl/dbg_resp_tx.sv
module dbg_resp_tx
   import dbg_runctl_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load_v,
   input  logic [2:0]  load_n,
   input  logic [31:0] load_word,
   input  logic        tx_ready,
   output logic        tx_valid,
   output logic [7:0]  tx_data
);

   logic [2:0]  left_q;
   logic [31:0] buf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         buf_q  <= '0;
      end else if (load_v) begin
         left_q <= load_n;
         buf_q  <= load_word;
      end else if (tx_valid && tx_ready) begin
         left_q <= left_q - 1'b1;
         buf_q  <= {8'h00, buf_q[31:8]};
      end
   end

   assign tx_valid = (left_q != '0);
   assign tx_data  = buf_q[7:0];

endmodule

// File: rtl/dbg_runctl.sv
module dbg_runctl
   import dbg_runctl_pkg::*;
#(
   parameter int unsigned IMEM_AW   = 10,
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned REG_IDX_W = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_valid,
   input  logic [7:0]           rx_data,
   output logic                 tx_valid,
   output logic [7:0]           tx_data,
   input  logic                 tx_ready,
   output logic                 core_clk_en,
   output logic                 core_stall,
   input  logic                 core_retire,
   output logic                 imem_we,
   output logic [IMEM_AW-1:0]   imem_waddr,
   output logic [31:0]          imem_wdata,
   output logic [REG_IDX_W-1:0] snoop_idx,
   input  logic [31:0]          snoop_data,
   output logic                 bus_own,
   output logic                 bus_rd,
   output logic [31:0]          bus_addr,
   input  logic [31:0]          bus_rdata
);

   if (IMEM_AW < 2 || IMEM_AW > 30) begin : g_bad_aw
      $error("dbg_runctl: IMEM_AW must lie in 2..30");
   end
   if (LEN_W < 16 || (LEN_W % 8) != 0) begin : g_bad_len
      $error("dbg_runctl: LEN_W must be a multiple of 8 and at least 16");
   end
   if (REG_IDX_W < 1 || REG_IDX_W > 8) begin : g_bad_idx
      $error("dbg_runctl: REG_IDX_W must lie in 1..8");
   end

   run_mode_e   mode;
   logic        go_run, go_instr, go_cycle, go_stop;
   logic        load_open, load_close, load_byte_v;
   logic [7:0]  load_byte;
   logic        peek_reg, peek_mem, peek_refused;
   logic        loading, rb_busy, rb_word_v;
   logic [31:0] rb_word;
   logic        rsp_v;
   logic [2:0]  rsp_n;
   logic [31:0] rsp_word;

   dbg_cmd_decode #(.LEN_W(LEN_W), .REG_IDX_W(REG_IDX_W)) u_decode (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_valid     (rx_valid),
      .rx_data      (rx_data),
      .halted       (mode == RM_HALT),
      .loading      (loading),
      .go_run       (go_run),
      .go_instr     (go_instr),
      .go_cycle     (go_cycle),
      .go_stop      (go_stop),
      .load_open    (load_open),
      .load_close   (load_close),
      .load_byte_v  (load_byte_v),
      .load_byte    (load_byte),
      .peek_reg     (peek_reg),
      .peek_mem     (peek_mem),
      .peek_refused (peek_refused),
      .reg_idx      (snoop_idx),
      .mem_addr     (bus_addr)
   );

   dbg_prog_loader #(.AW(IMEM_AW)) u_loader (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_open  (load_open),
      .load_close (load_close),
      .byte_v     (load_byte_v),
      .byte_d     (load_byte),
      .loading    (loading),
      .imem_we    (imem_we),
      .imem_waddr (imem_waddr),
      .imem_wdata (imem_wdata)
   );

   dbg_exec_ctl u_exec (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_run      (go_run),
      .go_instr    (go_instr),
      .go_cycle    (go_cycle),
      .go_stop     (go_stop),
      .retire      (core_retire),
      .loading     (loading),
      .bus_busy    (rb_busy),
      .mode        (mode),
      .core_clk_en (core_clk_en),
      .core_stall  (core_stall)
   );

   dbg_readback u_readback (
      .clk       (clk),
      .rst_n     (rst_n),
      .peek_reg  (peek_reg),
      .peek_mem  (peek_mem),
      .reg_data  (snoop_data),
      .mem_rdata (bus_rdata),
      .bus_own   (bus_own),
      .bus_rd    (bus_rd),
      .busy      (rb_busy),
      .word_v    (rb_word_v),
      .word      (rb_word)
   );

   always_comb begin
      rsp_v    = 1'b1;
      rsp_n    = 3'd1;
      rsp_word = '0;
      if (rb_word_v) begin
         rsp_n    = 3'(WORD_BYTES);
         rsp_word = rb_word;
      end else if (peek_refused) begin
         rsp_word = {24'h0, RSP_REFUSED};
      end else if (go_stop) begin
         rsp_word = {24'h0, RSP_STOPPED};
      end else begin
         rsp_v = 1'b0;
      end
   end

   dbg_resp_tx u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_v    (rsp_v),
      .load_n    (rsp_n),
      .load_word (rsp_word),
      .tx_ready  (tx_ready),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data)
   );

endmodule

// File: rtl/dbg_runctl_chk.sv
module dbg_runctl_chk
   import dbg_runctl_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       core_clk_en,
   input logic       core_stall,
   input logic       core_retire,
   input run_mode_e  mode,
   input logic       bus_own,
   input logic       bus_rd,
   input logic       imem_we,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic [7:0] tx_data
);

   // R12: bus ownership freezes the core
   a_r12_own_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      bus_own |-> (core_stall && !core_clk_en));

   // R12: program writes happen with the core frozen
   a_r12_load_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      imem_we |-> (core_stall && !core_clk_en));

   // R9: read strobe only under ownership
   a_r9_rd_owned: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |-> bus_own);

   // R9: one read strobe per access
   a_r9_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> !bus_rd);

   // R4: retire during an instruction step ends the enable
   a_r4_retire_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == RM_INSTR && core_retire) |=> !core_clk_en);

   // R3: a cycle step lasts one cycle
   a_r3_cycle_single: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == RM_CYCLE) |=> !core_clk_en);

   // R8: reply bytes hold under back-pressure
   a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

endmodule

bind dbg_runctl dbg_runctl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .core_clk_en (core_clk_en),
   .core_stall  (core_stall),
   .core_retire (core_retire),
   .mode        (mode),
   .bus_own     (bus_own),
   .bus_rd      (bus_rd),
   .imem_we     (imem_we),
   .tx_valid    (tx_valid),
   .tx_ready    (tx_ready),
   .tx_data     (tx_data)
);

// File: tb/dbg_runctl_tb_top.sv
`timescale 1ns/1ps
module dbg_runctl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = 8'h00;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_ready = 1'b1;
   logic        core_clk_en, core_stall, core_retire;
   logic        imem_we;
   logic [9:0]  imem_waddr;
   logic [31:0] imem_wdata;
   logic [4:0]  snoop_idx;
   logic [31:0] snoop_data;
   logic        bus_own, bus_rd;
   logic [31:0] bus_addr;
   logic [31:0] bus_rdata;

   always #2.5 clk = ~clk;

   dbg_runctl dut_i (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .core_clk_en(core_clk_en), .core_stall(core_stall), .core_retire(core_retire),
      .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
      .snoop_idx(snoop_idx), .snoop_data(snoop_data),
      .bus_own(bus_own), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
   );

   // model core: retires on every third enabled cycle
   logic [1:0]  phase;
   logic [31:0] cyc, rets;
   always @(posedge clk) begin
      if (!rst_n) begin
         phase <= 2'd0; cyc <= 32'd0; rets <= 32'd0;
      end else if (core_clk_en) begin
         cyc <= cyc + 1;
         if (phase == 2'd2) begin phase <= 2'd0; rets <= rets + 1; end
         else phase <= phase + 2'd1;
      end
   end
   assign core_retire = core_clk_en && (phase == 2'd2);
   assign snoop_data  = (snoop_idx == 5'd1) ? cyc :
                        (snoop_idx == 5'd2) ? rets : (32'hC0DE0000 | 32'(snoop_idx));

   // memory model shared by load port and read bus
   logic [31:0] ram [64];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) ram[i] <= 32'hDEAD0000 + 32'(i);
         bus_rdata <= 32'h0;
      end else begin
         if (imem_we) ram[imem_waddr[5:0]] <= imem_wdata;
         if (bus_rd) bus_rdata <= ram[bus_addr[7:2]];
      end
   end

   // port observation away from the active edge
   int en_cnt = 0, we_cnt = 0, own_cnt = 0, rxn = 0;
   logic [7:0] rxb [32];
   always @(negedge clk) begin
      if (rst_n) begin
         if (core_clk_en) en_cnt++;
         if (imem_we) we_cnt++;
         if (bus_own) own_cnt++;
         if (tx_valid && tx_ready) begin
            if (rxn < 32) rxb[rxn] = tx_data;
            rxn++;
         end
      end
   end

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk); rx_valid = 1'b1; rx_data = b;
      @(negedge clk); rx_valid = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic clear_rx();
      @(negedge clk); rxn = 0;
   endtask

   task automatic peek_mem(input logic [31:0] a, output logic [31:0] w, output int n);
      clear_rx();
      send(8'h21); send(a[7:0]); send(a[15:8]); send(a[23:16]); send(a[31:24]);
      repeat (12) @(negedge clk);
      n = rxn;
      w = {rxb[3], rxb[2], rxb[1], rxb[0]};
   endtask

   task automatic peek_reg(input logic [7:0] idx, output logic [31:0] w, output int n);
      clear_rx();
      send(8'h20); send(idx);
      repeat (10) @(negedge clk);
      n = rxn;
      w = {rxb[3], rxb[2], rxb[1], rxb[0]};
   endtask

   task automatic t_reset();
      chk("R1 clk_en after reset", 32'(core_clk_en), 32'd0);
      chk("R1 stall after reset", 32'(core_stall), 32'd1);
      chk("R1 tx_valid after reset", 32'(tx_valid), 32'd0);
      chk("R1 bus_own after reset", 32'(bus_own), 32'd0);
      chk("R1 imem_we after reset", 32'(imem_we), 32'd0);
   endtask

   task automatic t_unknown();
      int e0;
      e0 = en_cnt;
      clear_rx();
      send(8'h55); send(8'h02); send(8'hFF);
      repeat (10) @(negedge clk);
      chk("R13 no reply to unknown bytes", 32'(rxn), 32'd0);
      chk("R13 no enable from unknown bytes", 32'(en_cnt - e0), 32'd0);
   endtask

   task automatic t_load();
      int e0, w0, n;
      logic [31:0] w;
      e0 = en_cnt; w0 = we_cnt;
      send(8'h01); send(8'h06); send(8'h00);
      send(8'h10); send(8'h11); send(8'h12); send(8'h13); send(8'h21); send(8'h02);
      send(8'h10); send(8'h12); send(8'h11);
      repeat (10) @(negedge clk);
      chk("R7 run/step ignored while loading", 32'(en_cnt - e0), 32'd0);
      chk("R6 one full word written", 32'(we_cnt - w0), 32'd1);
      send(8'h02);
      peek_mem(32'h0, w, n);
      chk("R9 memory reply length", 32'(n), 32'd4);
      chk("R6 word 0 packed little-endian", w, 32'h13121110);
      peek_mem(32'h4, w, n);
      chk("R6 partial word dropped", w, 32'hDEAD0001);
      chk("R9 core frozen during reads", 32'(en_cnt - e0), 32'd0);
   endtask

   task automatic t_reg();
      logic [31:0] w; int n; int o0;
      o0 = own_cnt;
      peek_reg(8'hE5, w, n);
      chk("R8 register reply length", 32'(n), 32'd4);
      chk("R8 register value, index low 5 bits", w, 32'hC0DE0005);
      chk("R8 register read leaves bus alone", 32'(own_cnt - o0), 32'd0);
   endtask

   task automatic t_mem_own();
      logic [31:0] w; int n; int o0;
      o0 = own_cnt;
      peek_mem(32'h8, w, n);
      chk("R9 bus held two cycles", 32'(own_cnt - o0), 32'd2);
      chk("R9 data at byte address 8", w, 32'hDEAD0002);
   endtask

   task automatic t_step_cycle();
      int e0; logic [31:0] w; int n;
      e0 = en_cnt;
      send(8'h12);
      repeat (10) @(negedge clk);
      chk("R3 one enabled cycle", 32'(en_cnt - e0), 32'd1);
      peek_reg(8'h01, w, n);
      chk("R3 core cycle count", w, 32'd1);
   endtask

   task automatic t_step_instr();
      int e0; logic [31:0] w; int n;
      e0 = en_cnt;
      send(8'h11);
      repeat (12) @(negedge clk);
      chk("R4 step ends at retire (from mid-instruction)", 32'(en_cnt - e0), 32'd2);
      peek_reg(8'h02, w, n);
      chk("R4 one instruction retired", w, 32'd1);
      e0 = en_cnt;
      send(8'h11);
      repeat (12) @(negedge clk);
      chk("R4 full instruction step", 32'(en_cnt - e0), 32'd3);
      peek_reg(8'h02, w, n);
      chk("R4 second instruction retired", w, 32'd2);
   endtask

   task automatic t_run_stop();
      int e0;
      send(8'h10);
      repeat (20) @(negedge clk);
      chk("R2 enable held during free-run", 32'(core_clk_en), 32'd1);
      clear_rx();
      send(8'h13);
      repeat (6) @(negedge clk);
      chk("R5 stopped after stop command", 32'(core_clk_en), 32'd0);
      chk("R5 one acknowledge byte", 32'(rxn), 32'd1);
      chk("R5 acknowledge value", 32'(rxb[0]), 32'hA5);
      e0 = en_cnt;
      repeat (20) @(negedge clk);
      chk("R5 stays stopped", 32'(en_cnt - e0), 32'd0);
   endtask

   task automatic t_refuse();
      int o0;
      send(8'h10);
      clear_rx();
      o0 = own_cnt;
      send(8'h20); send(8'h03);
      send(8'h21); send(8'h00); send(8'h00); send(8'h00); send(8'h00);
      repeat (6) @(negedge clk);
      chk("R10 still running after refused reads", 32'(core_clk_en), 32'd1);
      send(8'h13);
      repeat (6) @(negedge clk);
      chk("R10 reply count", 32'(rxn), 32'd3);
      chk("R10 first refusal", 32'(rxb[0]), 32'hEE);
      chk("R10 second refusal", 32'(rxb[1]), 32'hEE);
      chk("R10 stop ack after refusals", 32'(rxb[2]), 32'hA5);
      chk("R10 no bus takeover while running", 32'(own_cnt - o0), 32'd0);
   endtask

   task automatic t_collide();
      int e0; logic [31:0] r0, w; int n;
      send(8'h11);
      repeat (12) @(negedge clk);
      peek_reg(8'h02, r0, n);
      clear_rx();
      e0 = en_cnt;
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'h11;
      @(negedge clk); rx_valid = 1'b0;
      @(negedge clk);
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'h13;
      @(negedge clk); rx_valid = 1'b0;
      repeat (12) @(negedge clk);
      chk("R11 stopped after collision", 32'(core_clk_en), 32'd0);
      chk("R11 three enabled cycles", 32'(en_cnt - e0), 32'd3);
      chk("R11 exactly one acknowledge", 32'(rxn), 32'd1);
      chk("R11 acknowledge value", 32'(rxb[0]), 32'hA5);
      peek_reg(8'h02, w, n);
      chk("R11 exactly one instruction retired", w, r0 + 32'd1);
      clear_rx();
      send(8'h13);
      repeat (6) @(negedge clk);
      chk("R5 acknowledge while already stopped", 32'(rxb[0]), 32'hA5);
      chk("R5 single byte while already stopped", 32'(rxn), 32'd1);
   endtask

   task automatic t_backpressure();
      logic [31:0] w;
      clear_rx();
      tx_ready = 1'b0;
      send(8'h20); send(8'h07);
      repeat (10) @(negedge clk);
      chk("R8 byte held under back-pressure", 32'(tx_data), 32'h07);
      tx_ready = 1'b1;
      repeat (8) @(negedge clk);
      w = {rxb[3], rxb[2], rxb[1], rxb[0]};
      chk("R8 value after back-pressure", w, 32'hC0DE0007);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unknown();
      t_load();
      t_reg();
      t_mem_own();
      t_step_cycle();
      t_step_instr();
      t_run_stop();
      t_refuse();
      t_collide();
      t_backpressure();
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL R1 watchdog expired");
      finish_run();
   end

endmodule